// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms the addresses a segmented 16-bit processor puts on its buses. For a memory access it takes a 16-bit offset and picks one of four 16-bit segment base values. It shifts that base left by four bits and adds the offset, which gives a 20-bit physical address inside a one-megabyte space. The segment is normally chosen by the class of the base register the offset was formed from. An explicit segment selection carried by the instruction takes priority over that default.

For an I/O access the block forms a 16-bit port number in one of two ways. In direct form it uses an 8-bit immediate and reaches only the lowest 256 ports. In indirect form it uses a 16-bit register value and reaches all 65,536 ports. Both paths are computed every cycle. The caller picks whichever result the current bus cycle needs. The segment base values come in from the register file as plain inputs.

With the default setting the outputs are registered. A result is valid one clock after the inputs that produced it. A parameter gives a purely combinational variant.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment value multiplied by 16, plus `mem_offset`, truncated to 20 bits.
- R2: A sum of 2^20 or more discards its carry and wraps. For example, segment FFFF with offset 0010 gives 00000.
- R3: With `ovr_valid` low and `base_ptr` high (a stack/frame pointer base), the stack segment is used and `seg_used` reads 2'b10.
- R4: With `ovr_valid` low and `base_ptr` low (an index base), the data segment is used and `seg_used` reads 2'b11.
- R5: With `ovr_valid` high, `ovr_code` selects the segment regardless of `base_ptr`. The codes are 2'b00 extra (`seg_es`), 2'b01 code (`seg_cs`), 2'b10 stack (`seg_ss`) and 2'b11 data (`seg_ds`).
- R6: With `io_indirect` low, `io_port` equals `{8'h00, io_imm}`, and `io_reg` has no effect on it.
- R7: With `io_indirect` high, `io_port` equals `io_reg`, and `io_imm` has no effect on it.
- R8: With REG_OUT=1, every output shows the result of the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears all outputs to zero.
- R9: The memory and I/O paths are independent. I/O inputs never change `phys_addr` or `seg_used`, and memory inputs never change `io_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_offset | input | 16 | Offset within the segment |
| base_ptr | input | 1 | 1: offset built from a pointer register; 0: from an index register |
| ovr_valid | input | 1 | Explicit segment selection present |
| ovr_code | input | 2 | Explicit segment code |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| io_indirect | input | 1 | 1: port from register; 0: port from immediate |
| io_imm | input | 8 | Immediate port number |
| io_reg | input | 16 | Register port number |
| phys_addr | output | 20 | Physical memory address |
| seg_used | output | 2 | Code of the segment that was applied |
| io_port | output | 16 | I/O port number |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the default segment choice and an explicit override. The bench provokes this by raising `ovr_valid` while `base_ptr` also names a default, for every override code. It judges the result by `seg_used` and by `phys_addr` taken from the overriding segment. The second pair is a memory address and a port number formed in the same cycle. The bench changes only the I/O inputs between two cycles and requires `phys_addr` to stay put. It then changes only the memory inputs and requires `io_port` to stay put.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int PHYS_W  = SEG_W + SHIFT;
  localparam int NUM_SEG = 4;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_code_e;
endpackage

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int W = SEG_W
) (
  input  logic                   base_ptr,
  input  logic                   ovr_valid,
  input  logic [1:0]             ovr_code,
  input  logic [NUM_SEG-1:0][W-1:0] seg_bank,
  output seg_code_e              code,
  output logic [W-1:0]           seg_val
);
  seg_code_e dflt;

  always_comb begin
    dflt = base_ptr ? SEG_STACK : SEG_DATA;
    code = ovr_valid ? seg_code_e'(ovr_code) : dflt;
    seg_val = seg_bank[code];
  end

  always_comb begin
    if (!ovr_valid) assert (code == SEG_STACK || code == SEG_DATA)
      else $error("a_r4_default_class");
  end
endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
  parameter int SW = 16,
  parameter int OW = 16,
  parameter int SH = 4
) (
  input  logic [SW-1:0]    seg_val,
  input  logic [OW-1:0]    offset,
  output logic [SW+SH-1:0] phys
);
  localparam int PW = SW + SH;
  logic [PW-1:0] base_ext;
  logic [PW-1:0] off_ext;

  always_comb begin
    base_ext = {seg_val, {SH{1'b0}}};
    off_ext  = PW'(offset);
    phys     = base_ext + off_ext;
  end
endmodule

// File: rtl/io_port_former.sv
module io_port_former #(
  parameter int PW = 16,
  parameter int IW = 8
) (
  input  logic          indirect,
  input  logic [IW-1:0] imm,
  input  logic [PW-1:0] reg_val,
  output logic [PW-1:0] port
);
  localparam int PAD = PW - IW;

  always_comb begin
    port = indirect ? reg_val : {{PAD{1'b0}}, imm};
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int PORT_W  = 16,
  parameter int IMM_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OFF_W-1:0]    mem_offset,
  input  logic                base_ptr,
  input  logic                ovr_valid,
  input  logic [1:0]          ovr_code,
  input  logic [SEG_W-1:0]    seg_es,
  input  logic [SEG_W-1:0]    seg_cs,
  input  logic [SEG_W-1:0]    seg_ss,
  input  logic [SEG_W-1:0]    seg_ds,
  input  logic                io_indirect,
  input  logic [IMM_W-1:0]    io_imm,
  input  logic [PORT_W-1:0]   io_reg,
  output logic [PHYS_W-1:0]   phys_addr,
  output logic [1:0]          seg_used,
  output logic [PORT_W-1:0]   io_port
);
  logic [NUM_SEG-1:0][SEG_W-1:0] bank;
  seg_code_e                     code_c;
  logic [SEG_W-1:0]              seg_c;
  logic [PHYS_W-1:0]             phys_c;
  logic [PORT_W-1:0]             port_c;

  assign bank[SEG_EXTRA] = seg_es;
  assign bank[SEG_CODE]  = seg_cs;
  assign bank[SEG_STACK] = seg_ss;
  assign bank[SEG_DATA]  = seg_ds;

  seg_select #(.W(SEG_W)) u_sel (
    .base_ptr (base_ptr),
    .ovr_valid(ovr_valid),
    .ovr_code (ovr_code),
    .seg_bank (bank),
    .code     (code_c),
    .seg_val  (seg_c)
  );

  phys_adder #(.SW(SEG_W), .OW(OFF_W), .SH(SHIFT)) u_add (
    .seg_val(seg_c),
    .offset (mem_offset),
    .phys   (phys_c)
  );

  io_port_former #(.PW(PORT_W), .IW(IMM_W)) u_io (
    .indirect(io_indirect),
    .imm     (io_imm),
    .reg_val (io_reg),
    .port    (port_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          phys_addr <= '0;
          seg_used  <= '0;
          io_port   <= '0;
        end else begin
          phys_addr <= phys_c;
          seg_used  <= code_c;
          io_port   <= port_c;
        end
      end

      // R3
      a_r3_ptr_stack: assert property (@(posedge clk) disable iff (rst)
        (!ovr_valid && base_ptr) |=> (seg_used == 2'b10 &&
          phys_addr == PHYS_W'({$past(seg_ss), 4'h0} + PHYS_W'($past(mem_offset)))))
        else $error("a_r3_ptr_stack");
      // R4
      a_r4_idx_data: assert property (@(posedge clk) disable iff (rst)
        (!ovr_valid && !base_ptr) |=> (seg_used == 2'b11 &&
          phys_addr == PHYS_W'({$past(seg_ds), 4'h0} + PHYS_W'($past(mem_offset)))))
        else $error("a_r4_idx_data");
      // R5
      a_r5_override: assert property (@(posedge clk) disable iff (rst)
        ovr_valid |=> (seg_used == $past(ovr_code)))
        else $error("a_r5_override");
      // R6
      a_r6_direct_port: assert property (@(posedge clk) disable iff (rst)
        !io_indirect |=> (io_port == PORT_W'($past(io_imm))))
        else $error("a_r6_direct_port");
      // R7
      a_r7_indirect_port: assert property (@(posedge clk) disable iff (rst)
        io_indirect |=> (io_port == $past(io_reg)))
        else $error("a_r7_indirect_port");
    end else begin : g_comb
      assign phys_addr = phys_c;
      assign seg_used  = code_c;
      assign io_port   = port_c;
    end
  endgenerate
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_offset = '0;
  logic        base_ptr = 1'b0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_code = '0;
  logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000, seg_ds = 16'h4000;
  logic        io_indirect = 1'b0;
  logic [7:0]  io_imm = '0;
  logic [15:0] io_reg = '0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;
  logic [15:0] io_port;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst(rst), .mem_offset(mem_offset), .base_ptr(base_ptr),
    .ovr_valid(ovr_valid), .ovr_code(ovr_code), .seg_es(seg_es), .seg_cs(seg_cs),
    .seg_ss(seg_ss), .seg_ds(seg_ds), .io_indirect(io_indirect), .io_imm(io_imm),
    .io_reg(io_reg), .phys_addr(phys_addr), .seg_used(seg_used), .io_port(io_port)
  );

  function automatic logic [19:0] exp_phys(logic [15:0] s, logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction

  function automatic logic [15:0] seg_of(logic [1:0] c);
    case (c)
      2'b00: return seg_es;
      2'b01: return seg_cs;
      2'b10: return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    mem_offset = 16'hBEEF; io_indirect = 1'b1; io_reg = 16'h5555;
    step(); step();
    check("R8 reset phys", 32'(phys_addr), 32'h0);
    check("R8 reset seg", 32'(seg_used), 32'h0);
    check("R8 reset port", 32'(io_port), 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_ptr_default();
    @(negedge clk);
    ovr_valid = 1'b0; base_ptr = 1'b1; mem_offset = 16'h0123;
    step();
    check("R3 seg", 32'(seg_used), 32'h2);
    check("R1 R3 phys", 32'(phys_addr), 32'(exp_phys(seg_ss, 16'h0123)));
  endtask

  task automatic t_idx_default();
    @(negedge clk);
    ovr_valid = 1'b0; base_ptr = 1'b0; mem_offset = 16'hF00D;
    step();
    check("R4 seg", 32'(seg_used), 32'h3);
    check("R1 R4 phys", 32'(phys_addr), 32'(exp_phys(seg_ds, 16'hF00D)));
  endtask

  task automatic t_override();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ovr_valid = 1'b1; ovr_code = 2'(c); base_ptr = c[0]; mem_offset = 16'h0040 + 16'(c);
      step();
      check("R5 seg", 32'(seg_used), 32'(c));
      check("R5 phys", 32'(phys_addr), 32'(exp_phys(seg_of(2'(c)), 16'h0040 + 16'(c))));
    end
    @(negedge clk); ovr_valid = 1'b0;
  endtask

  task automatic t_wrap();
    @(negedge clk);
    seg_ds = 16'hFFFF; base_ptr = 1'b0; mem_offset = 16'h0010;
    step();
    check("R2 wrap to zero", 32'(phys_addr), 32'h00000);
    @(negedge clk);
    mem_offset = 16'hFFFF;
    step();
    check("R2 wrap high", 32'(phys_addr), 32'h0FFEF);
    @(negedge clk);
    seg_ds = 16'hF000;
    step();
    check("R1 top of space", 32'(phys_addr), 32'hFFFFF);
    seg_ds = 16'h4000;
  endtask

  task automatic t_io();
    @(negedge clk);
    io_indirect = 1'b0; io_imm = 8'hA5; io_reg = 16'h1234;
    step();
    check("R6 direct", 32'(io_port), 32'h00A5);
    @(negedge clk);
    io_reg = 16'hFFFF;
    step();
    check("R6 reg ignored", 32'(io_port), 32'h00A5);
    @(negedge clk);
    io_indirect = 1'b1; io_imm = 8'h3C;
    step();
    check("R7 indirect", 32'(io_port), 32'hFFFF);
    @(negedge clk);
    io_imm = 8'h00;
    step();
    check("R7 imm ignored", 32'(io_port), 32'hFFFF);
  endtask

  task automatic t_latency();
    @(negedge clk);
    base_ptr = 1'b0; ovr_valid = 1'b0; mem_offset = 16'h0001;
    step();
    @(negedge clk);
    mem_offset = 16'h0002;
    #1;
    check("R8 old value held", 32'(phys_addr), 32'(exp_phys(seg_ds, 16'h0001)));
    step();
    check("R8 new after edge", 32'(phys_addr), 32'(exp_phys(seg_ds, 16'h0002)));
  endtask

  task automatic t_concurrent();
    logic [19:0] p0;
    logic [15:0] q0;
    @(negedge clk);
    base_ptr = 1'b1; mem_offset = 16'h0777; io_indirect = 1'b1; io_reg = 16'h0BAD;
    step();
    p0 = phys_addr; q0 = io_port;
    check("R9 both phys", 32'(p0), 32'(exp_phys(seg_ss, 16'h0777)));
    check("R9 both port", 32'(q0), 32'h0BAD);
    @(negedge clk);
    io_indirect = 1'b0; io_imm = 8'h77; io_reg = 16'h1111;
    step();
    check("R9 phys unmoved", 32'(phys_addr), 32'(p0));
    check("R9 seg unmoved", 32'(seg_used), 32'h2);
    @(negedge clk);
    mem_offset = 16'h9999; base_ptr = 1'b0; ovr_valid = 1'b1; ovr_code = 2'b01;
    step();
    check("R9 port unmoved", 32'(io_port), 32'h0077);
    @(negedge clk); ovr_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ptr_default();
    t_idx_default();
    t_override();
    t_wrap();
    t_io();
    t_latency();
    t_concurrent();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule